// File: doc/BRIEF.md
# Single-Wire Network Command Selector

This block is the network layer of a single-wire slave with a 64-bit node identifier. It sits between a bit-slot engine, which turns bus waveforms into slot events, and the function layer that owns memory and other device commands. After every bus reset it collects an 8-bit command, least significant bit first, and then runs one of seven selection procedures. These are: report the identifier, compare against an identifier sent by the master, take part in a bitwise search, select without addressing, re-select a device that was addressed before, and two selection variants that also switch the link to the fast timing mode.

The bit engine reports each finished slot with a one-cycle `slot_done_i` and the bit the master left on the line in `slot_bit_i`. Between slots the selector states through `slot_read_o` whether the next slot is one in which the slave transmits, and through `tx_bit_o` which bit it sends. When a procedure ends in selection, `grant_o` stays high until the next bus reset and hands the wire to the function layer. When it ends otherwise, the block stays silent until the next bus reset. Two flags outlive bus resets: `resume_o`, which records that the device was the last one addressed, and `overdrive_o`, which tells the bit engine to use fast timing. The identifier arrives on a static input. Received identifiers are not CRC-checked here.

Top module: `onew_rom_select`

## Requirements
- R1: After `rst`, `grant_o`, `slot_read_o`, `resume_o` and `overdrive_o` are all 0 and the block waits for a command byte. Bit k of the byte arrives in the k-th slot after a bus reset.
- R2: Code 8'h33 makes the next 64 slots transmit slots. In slot k, `tx_bit_o` equals `node_id_i[k]`. After the 64th slot `grant_o` rises. The command clears `resume_o`.
- R3: Code 8'h55 compares the next 64 received bits, bit k against `node_id_i[k]`. A full match raises `grant_o` and sets `resume_o`. On the first mismatch, the block drives no transmit slot and never grants until the next bus reset. In that case `resume_o` ends at 0.
- R4: Code 8'hF0 handles each identifier bit k in three slots: a transmit slot with `node_id_i[k]`, then a transmit slot with its complement, then a receive slot. A received bit unequal to `node_id_i[k]` drops the device out, with no further transmit slots and no grant until a bus reset, and `resume_o` at 0. Completing all 64 bits raises `grant_o` and sets `resume_o`.
- R5: Code 8'hCC raises `grant_o` right after the command byte and clears `resume_o`.
- R6: Code 8'hA5 raises `grant_o` only if `resume_o` is already 1, leaving it at 1. Otherwise the block stays silent and ungranted until the next bus reset.
- R7: Code 8'h3C sets `overdrive_o`, clears `resume_o` and raises `grant_o` right after the command byte.
- R8: Code 8'h69 sets `overdrive_o` as soon as the command byte ends, so the 64 compare bits come at fast timing. It then compares like R3: a full match grants and sets `resume_o`.
- R9: If the compare of code 8'h69 fails, `overdrive_o` returns to the value it had before that command. No other command lowers `overdrive_o`; only `rst` does.
- R10: Any other code clears `resume_o` and leaves the block silent and ungranted until the next bus reset.
- R11: A `bus_reset_i` pulse in any state drops `grant_o` on the next cycle, aborts the running procedure and restarts command collection. Both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | One-cycle pulse: the bit engine saw a reset pulse on the wire |
| slot_done_i | input | 1 | One-cycle pulse: a time slot finished |
| slot_bit_i | input | 1 | Bit sampled from the wire in the finished slot |
| node_id_i | input | 64 | The device identifier, bit 0 sent first |
| slot_read_o | output | 1 | Next slot is one in which the slave transmits |
| tx_bit_o | output | 1 | Bit to send in a transmit slot (1 when not transmitting) |
| grant_o | output | 1 | Function layer owns the wire until the next bus reset |
| resume_o | output | 1 | Device may be re-selected without addressing |
| overdrive_o | output | 1 | Fast slot timing selected |

## Verification
The hardest situation to reach is a failed fast-mode compare whose outcome depends on history. Whether `overdrive_o` falls or stays up depends on whether an earlier command, possibly several bus resets back, had already set it. The random sequence keeps a reference model of both flags across bus resets and only occasionally applies `rst`. Failed compares therefore land both on a cleared and on an already-set flag. Mismatch positions are drawn at random, including the first and last identifier bit, so dropping out is observed at both ends of the walk.

// File: rtl/onew_rom_pkg.sv
package onew_rom_pkg;

    localparam int ID_BITS  = 64;
    localparam int CMD_BITS = 8;

    localparam logic [CMD_BITS-1:0] OP_READ     = 8'h33;
    localparam logic [CMD_BITS-1:0] OP_MATCH    = 8'h55;
    localparam logic [CMD_BITS-1:0] OP_SEARCH   = 8'hF0;
    localparam logic [CMD_BITS-1:0] OP_SKIP     = 8'hCC;
    localparam logic [CMD_BITS-1:0] OP_RESUME   = 8'hA5;
    localparam logic [CMD_BITS-1:0] OP_OD_SKIP  = 8'h3C;
    localparam logic [CMD_BITS-1:0] OP_OD_MATCH = 8'h69;

    typedef enum logic [2:0] {
        ACT_READ,
        ACT_MATCH,
        ACT_OD_MATCH,
        ACT_SEARCH,
        ACT_SKIP,
        ACT_OD_SKIP,
        ACT_RESUME,
        ACT_NONE
    } rom_act_e;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SR_TRUE,
        ST_SR_COMP,
        ST_SR_PICK,
        ST_GRANT,
        ST_IDLE
    } sel_state_e;

    typedef struct packed {
        logic cmd_start;
        logic od_begin;
        logic od_set;
        logic match_fail;
        logic clr_res;
        logic set_res;
    } flag_ctl_t;

    function automatic rom_act_e decode_op(input logic [CMD_BITS-1:0] code);
        rom_act_e act;
        case (code)
            OP_READ:     act = ACT_READ;
            OP_MATCH:    act = ACT_MATCH;
            OP_OD_MATCH: act = ACT_OD_MATCH;
            OP_SEARCH:   act = ACT_SEARCH;
            OP_SKIP:     act = ACT_SKIP;
            OP_OD_SKIP:  act = ACT_OD_SKIP;
            OP_RESUME:   act = ACT_RESUME;
            default:     act = ACT_NONE;
        endcase
        return act;
    endfunction

    function automatic logic is_tx_state(input sel_state_e st);
        return (st == ST_READ) || (st == ST_SR_TRUE) || (st == ST_SR_COMP);
    endfunction

endpackage

// File: rtl/onew_cmd_rx.sv
module onew_cmd_rx
    import onew_rom_pkg::*;
#(
    parameter int CMD_W = CMD_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             slot_done_i,
    input  logic             slot_bit_i,
    output logic             byte_done_o,
    output logic [CMD_W-1:0] code_o
);
    localparam int CNT_W = $clog2(CMD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

    logic [CMD_W-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;

    assign take        = en_i && slot_done_i;
    assign code_o      = {slot_bit_i, sh_q[CMD_W-1:1]};
    assign byte_done_o = take && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (take) begin
            sh_q  <= code_o;
            cnt_q <= byte_done_o ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CMD_RESTART: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0)) else $error("command count not restarted"); // R11

endmodule

// File: rtl/onew_id_walk.sv
module onew_id_walk
    import onew_rom_pkg::*;
#(
    parameter int ID_W = ID_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_i,
    input  logic            inc_i,
    input  logic [ID_W-1:0] node_id_i,
    output logic            id_bit_o,
    output logic            last_o
);
    localparam int IDX_W = $clog2(ID_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

    logic [IDX_W-1:0] idx_q;

    assign id_bit_o = node_id_i[idx_q];
    assign last_o   = (idx_q == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            idx_q <= '0;
        end else if (inc_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        inc_i |-> !last_o) else $error("identifier index overrun"); // R2

endmodule

// File: rtl/onew_rom_flags.sv
module onew_rom_flags
    import onew_rom_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_ctl_t ctl_i,
    output logic      resume_o,
    output logic      od_o
);
    logic res_q;
    logic od_q;
    logic od_prev_q;
    logic od_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= 1'b0;
            od_q      <= 1'b0;
            od_prev_q <= 1'b0;
            od_pend_q <= 1'b0;
        end else begin
            if (ctl_i.cmd_start) begin
                od_pend_q <= ctl_i.od_begin;
                if (ctl_i.od_begin) begin
                    od_prev_q <= od_q;
                    od_q      <= 1'b1;
                end
            end
            if (ctl_i.od_set) begin
                od_q <= 1'b1;
            end
            if (ctl_i.match_fail && od_pend_q) begin
                od_q <= od_prev_q;
            end
            if (ctl_i.clr_res) begin
                res_q <= 1'b0;
            end
            if (ctl_i.set_res) begin
                res_q <= 1'b1;
            end
        end
    end

    assign resume_o = res_q;
    assign od_o     = od_q;

    AST_OD_DROP_ONLY_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
        $fell(od_q) |-> $past(od_pend_q)) else $error("fast mode lost outside a failed compare"); // R9

    AST_RES_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        !(ctl_i.set_res && ctl_i.clr_res)) else $error("resume set and cleared together"); // R3

endmodule

// File: rtl/onew_rom_select.sv
module onew_rom_select
    import onew_rom_pkg::*;
#(
    parameter int ID_W = ID_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_reset_i,
    input  logic            slot_done_i,
    input  logic            slot_bit_i,
    input  logic [ID_W-1:0] node_id_i,
    output logic            slot_read_o,
    output logic            tx_bit_o,
    output logic            grant_o,
    output logic            resume_o,
    output logic            overdrive_o
);
    sel_state_e          state_q;
    sel_state_e          state_d;
    flag_ctl_t           fctl;
    logic                byte_done;
    logic [CMD_BITS-1:0] code;
    logic                id_bit;
    logic                id_last;
    logic                walk_clr;
    logic                walk_inc;
    logic                bit_miss;

    onew_cmd_rx #(.CMD_W(CMD_BITS)) u_cmd_rx (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (bus_reset_i),
        .en_i        (state_q == ST_CMD),
        .slot_done_i (slot_done_i),
        .slot_bit_i  (slot_bit_i),
        .byte_done_o (byte_done),
        .code_o      (code)
    );

    onew_id_walk #(.ID_W(ID_W)) u_id_walk (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (walk_clr),
        .inc_i     (walk_inc),
        .node_id_i (node_id_i),
        .id_bit_o  (id_bit),
        .last_o    (id_last)
    );

    onew_rom_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (fctl),
        .resume_o (resume_o),
        .od_o     (overdrive_o)
    );

    assign bit_miss = (slot_bit_i != id_bit);

    always_comb begin
        state_d  = state_q;
        fctl     = '0;
        walk_clr = 1'b0;
        walk_inc = 1'b0;
        if (bus_reset_i) begin
            state_d  = ST_CMD;
            walk_clr = 1'b1;
        end else begin
            case (state_q)
                ST_CMD: begin
                    if (byte_done) begin
                        walk_clr       = 1'b1;
                        fctl.cmd_start = 1'b1;
                        case (decode_op(code))
                            ACT_READ: begin
                                state_d      = ST_READ;
                                fctl.clr_res = 1'b1;
                            end
                            ACT_MATCH: begin
                                state_d      = ST_MATCH;
                                fctl.clr_res = 1'b1;
                            end
                            ACT_OD_MATCH: begin
                                state_d       = ST_MATCH;
                                fctl.clr_res  = 1'b1;
                                fctl.od_begin = 1'b1;
                            end
                            ACT_SEARCH: begin
                                state_d      = ST_SR_TRUE;
                                fctl.clr_res = 1'b1;
                            end
                            ACT_SKIP: begin
                                state_d      = ST_GRANT;
                                fctl.clr_res = 1'b1;
                            end
                            ACT_OD_SKIP: begin
                                state_d      = ST_GRANT;
                                fctl.clr_res = 1'b1;
                                fctl.od_set  = 1'b1;
                            end
                            ACT_RESUME: begin
                                state_d = resume_o ? ST_GRANT : ST_IDLE;
                            end
                            default: begin
                                state_d      = ST_IDLE;
                                fctl.clr_res = 1'b1;
                            end
                        endcase
                    end
                end
                ST_READ: begin
                    if (slot_done_i) begin
                        if (id_last) state_d = ST_GRANT;
                        else         walk_inc = 1'b1;
                    end
                end
                ST_MATCH: begin
                    if (slot_done_i) begin
                        if (bit_miss) begin
                            state_d         = ST_IDLE;
                            fctl.match_fail = 1'b1;
                        end else if (id_last) begin
                            state_d      = ST_GRANT;
                            fctl.set_res = 1'b1;
                        end else begin
                            walk_inc = 1'b1;
                        end
                    end
                end
                ST_SR_TRUE: begin
                    if (slot_done_i) state_d = ST_SR_COMP;
                end
                ST_SR_COMP: begin
                    if (slot_done_i) state_d = ST_SR_PICK;
                end
                ST_SR_PICK: begin
                    if (slot_done_i) begin
                        if (bit_miss) begin
                            state_d = ST_IDLE;
                        end else if (id_last) begin
                            state_d      = ST_GRANT;
                            fctl.set_res = 1'b1;
                        end else begin
                            state_d  = ST_SR_TRUE;
                            walk_inc = 1'b1;
                        end
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CMD;
        else     state_q <= state_d;
    end

    assign slot_read_o = is_tx_state(state_q);
    assign grant_o     = (state_q == ST_GRANT);

    always_comb begin
        case (state_q)
            ST_READ, ST_SR_TRUE: tx_bit_o = id_bit;
            ST_SR_COMP:          tx_bit_o = ~id_bit;
            default:             tx_bit_o = 1'b1;
        endcase
    end

    AST_RESET_DROPS_GRANT: assert property (@(posedge clk) disable iff (rst)
        bus_reset_i |=> !grant_o && !slot_read_o) else $error("bus reset did not abort"); // R11

    AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        grant_o && !bus_reset_i |=> grant_o) else $error("grant lost without bus reset"); // R11

    AST_RESUME_WITH_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(resume_o) |-> $rose(grant_o)) else $error("resume flag set without selection"); // R3

    AST_OD_FALL_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        $fell(overdrive_o) |-> !grant_o) else $error("fast mode dropped on a granted path"); // R9

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) && !bus_reset_i |=> (state_q == ST_IDLE) && !slot_read_o) else $error("idle device woke up"); // R10

endmodule

// File: tb/onew_rom_select_bench.sv
module onew_rom_select_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_reset_i = 1'b0;
    logic        slot_done_i = 1'b0;
    logic        slot_bit_i = 1'b1;
    logic [63:0] node_id_i = 64'h0;
    logic        slot_read_o, tx_bit_o, grant_o, resume_o, overdrive_o;

    int checks = 0;
    int errors = 0;
    bit m_res = 1'b0;
    bit m_od  = 1'b0;

    always #2 clk = ~clk;

    onew_rom_select u_onew_rom_select (
        .clk         (clk),
        .rst         (rst),
        .bus_reset_i (bus_reset_i),
        .slot_done_i (slot_done_i),
        .slot_bit_i  (slot_bit_i),
        .node_id_i   (node_id_i),
        .slot_read_o (slot_read_o),
        .tx_bit_o    (tx_bit_o),
        .grant_o     (grant_o),
        .resume_o    (resume_o),
        .overdrive_o (overdrive_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic slot(input bit b);
        @(negedge clk);
        slot_bit_i  = b;
        slot_done_i = 1'b1;
        @(negedge clk);
        slot_done_i = 1'b0;
        slot_bit_i  = 1'b1;
    endtask

    task automatic bus_rst();
        @(negedge clk);
        bus_reset_i = 1'b1;
        @(negedge clk);
        bus_reset_i = 1'b0;
        chk(grant_o == 1'b0, "R11 grant after bus reset", grant_o, 0);
    endtask

    task automatic hard_rst();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_res = 0;
        m_od  = 0;
        chk({grant_o, slot_read_o, resume_o, overdrive_o} == 4'b0, "R1 reset state",
            {grant_o, slot_read_o, resume_o, overdrive_o}, 0);
    endtask

    task automatic send_byte(input logic [7:0] c);
        for (int i = 0; i < 8; i++) slot(c[i]);
    endtask

    task automatic check_end(input bit exp_grant, input string req);
        chk(grant_o == exp_grant, {req, " grant"}, grant_o, exp_grant);
        chk(resume_o == m_res, {req, " resume flag"}, resume_o, m_res);
        chk(overdrive_o == m_od, {req, " overdrive flag"}, overdrive_o, m_od);
    endtask

    task automatic t_read();
        bit ok = 1'b1;
        send_byte(8'h33);
        m_res = 0;
        for (int i = 0; i < 64; i++) begin
            if (!(slot_read_o && tx_bit_o == node_id_i[i])) begin
                ok = 1'b0;
                chk(0, "R2 id bit", {slot_read_o, tx_bit_o}, {1'b1, node_id_i[i]});
            end
            slot(1'b1);
        end
        chk(ok, "R2 identifier stream", 0, 0);
        check_end(1'b1, "R2");
    endtask

    task automatic t_match(input bit od, input int err);
        bit prev = m_od;
        send_byte(od ? 8'h69 : 8'h55);
        m_res = 0;
        if (od) begin
            m_od = 1;
            chk(overdrive_o == 1'b1, "R8 fast mode at command end", overdrive_o, 1);
        end
        for (int i = 0; i < 64; i++) begin
            if (slot_read_o) chk(0, "R3 no transmit during compare", slot_read_o, 0);
            slot(node_id_i[i] ^ (i == err));
        end
        if (err < 0) m_res = 1;
        else if (od) m_od = prev;
        check_end(err < 0, od ? (err < 0 ? "R8" : "R9") : "R3");
    endtask

    task automatic t_search(input int err);
        bool_dummy: begin end
        send_byte(8'hF0);
        m_res = 0;
        for (int i = 0; i < 64; i++) begin
            if (err >= 0 && i > err) begin
                chk(slot_read_o == 1'b0, "R4 dropped out stays silent", slot_read_o, 0);
                slot(1'b1); slot(1'b1); slot(node_id_i[i]);
            end else begin
                if (!(slot_read_o && tx_bit_o == node_id_i[i]))
                    chk(0, "R4 true bit", {slot_read_o, tx_bit_o}, {1'b1, node_id_i[i]});
                slot(1'b1);
                if (!(slot_read_o && tx_bit_o == ~node_id_i[i]))
                    chk(0, "R4 complement bit", {slot_read_o, tx_bit_o}, {1'b1, ~node_id_i[i]});
                slot(1'b1);
                if (slot_read_o) chk(0, "R4 pick slot is receive", slot_read_o, 0);
                slot(node_id_i[i] ^ (i == err));
            end
        end
        if (err < 0) m_res = 1;
        check_end(err < 0, "R4");
    endtask

    task automatic t_skip(input bit od);
        send_byte(od ? 8'h3C : 8'hCC);
        m_res = 0;
        if (od) m_od = 1;
        check_end(1'b1, od ? "R7" : "R5");
    endtask

    task automatic t_resume();
        bit g = m_res;
        send_byte(8'hA5);
        check_end(g, "R6");
        slot(1'b1);
        chk(slot_read_o == 1'b0, "R6 no transmit after resume", slot_read_o, 0);
    endtask

    task automatic t_unknown();
        logic [7:0] c;
        do c = 8'($urandom);
        while (c == 8'h33 || c == 8'h55 || c == 8'hF0 || c == 8'hCC ||
               c == 8'hA5 || c == 8'h3C || c == 8'h69);
        send_byte(c);
        m_res = 0;
        for (int i = 0; i < 8; i++) begin
            if (slot_read_o) chk(0, "R10 silent after unknown code", slot_read_o, 0);
            slot(1'($urandom));
        end
        check_end(1'b0, "R10");
    endtask

    function automatic int pick_err();
        int r = $urandom_range(0, 3);
        if (r == 0) return 0;
        if (r == 1) return 63;
        return $urandom_range(0, 63);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_7a11));
        node_id_i = {$urandom, $urandom};
        hard_rst();

        // Directed corner cases
        bus_rst(); t_resume();            // R6 flag clear: no grant
        bus_rst(); t_match(1'b0, -1);     // R3 full match
        bus_rst(); t_resume();            // R6 flag set: grant
        bus_rst(); t_skip(1'b0);          // R5
        bus_rst(); t_resume();            // R6 cleared by skip
        bus_rst(); t_read();              // R2
        bus_rst(); t_search(-1);          // R4 success
        bus_rst(); t_search(0);           // R4 fail on first bit
        bus_rst(); t_match(1'b1, 63);     // R9 fail, flag was 0
        bus_rst(); t_skip(1'b1);          // R7
        bus_rst(); t_match(1'b1, 5);      // R9 fail, flag was 1: kept
        bus_rst(); t_unknown();           // R10

        // R11: abort a read midway, flags kept
        bus_rst();
        send_byte(8'h33);
        for (int i = 0; i < 10; i++) slot(1'b1);
        bus_rst();
        chk(slot_read_o == 1'b0, "R11 abort stops transmit", slot_read_o, 0);
        check_end(1'b0, "R11");
        t_skip(1'b0);

        // R11: reset midway through the command byte
        bus_rst();
        for (int i = 0; i < 4; i++) slot(1'b0);
        bus_rst();
        t_skip(1'b0);

        // Constrained random sequences
        for (int n = 0; n < 60; n++) begin
            int k = $urandom_range(0, 10);
            if (k == 10) hard_rst();
            bus_rst();
            case (k)
                0: t_read();
                1: t_match(1'b0, -1);
                2: t_match(1'b0, pick_err());
                3: t_match(1'b1, -1);
                4: t_match(1'b1, pick_err());
                5: t_search(($urandom_range(0, 1) == 0) ? -1 : pick_err());
                6: t_skip(1'b0);
                7: t_skip(1'b1);
                8: t_resume();
                default: t_unknown();
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule